// File: doc/BRIEF.md
# Two-Stage 8-bit Load/Store Core

This block is a small 8-bit processor core with separate program and data buses. Its instructions are 16-bit words, and its program counter counts words. It holds thirty-two 8-bit working registers and a status byte. It runs a fixed subset of operations:

- load immediate
- register add and subtract
- increment and decrement
- direct data load and store
- I/O input and output
- absolute jump

Any word it does not recognise behaves as a no-operation.

The core has two stages. An instruction register holds the word being executed, and in the same cycle the next word is read from program memory. Both memories read combinationally: the program word appears for the address the core drives, and the data byte appears for the data address it drives. Data writes take effect at the clock edge while the write strobe is high.

Direct load, direct store and jump take two words, and the second word is an absolute address. The core takes that address straight from the program bus while the first word executes. It then replaces the fetched address word with a no-operation.

I/O port numbers sit in data space at the port number plus 0x20. The one exception is port 0x3F, which reads and writes the status byte inside the core and never reaches the data bus.

Top module: `mcu8_core`

## Requirements
- R1: While reset is low, `imem_addr` is 0 and `dmem_we` is 0. After reset, every working register and the status byte read back as 0x00.
- R2: With no jump in execution, `imem_addr` rises by one at each clock edge. The first edge after reset release moves it from 0 to 1, and one instruction completes per cycle.
- R3: Word `1110 KKKK dddd KKKK` writes the byte KKKK:KKKK (high nibble in bits 11..8, low nibble in bits 3..0) into register 16+dddd. The status byte is not changed.
- R4: Word `0000 11rd dddd rrrr` (add) and word `0001 10rd dddd rrrr` (subtract) write Rd op Rr into Rd. The source field is bit 9 followed by bits 3..0; the destination is bits 8..4. The status byte layout is bit 7 I, bit 6 T, bit 5 H (carry or borrow out of bit 3), bit 4 S = N xor V, bit 3 V (signed overflow), bit 2 N (result bit 7), bit 1 Z (result zero) and bit 0 C (carry, or borrow when Rr > Rd unsigned). I and T are left as they were.
- R5: Word `1001 010d dddd 0011` increments Rd and word `1001 010d dddd 1010` decrements it. Both update S, V, N and Z and leave H and C unchanged. V is set when an increment gives 0x80 and when a decrement starts from 0x80.
- R6: Word `1001 000d dddd 0000` loads Rd from the data address held in the next word, and `1001 001r rrrr 0000` stores Rr to it. The address word is never executed as an instruction.
- R7: Word `1011 0AAd dddd AAAA` reads port A into Rd and `1011 1AAr rrrr AAAA` writes Rr to port A. The 6-bit port number is bits 10..9 followed by bits 3..0. Port A is reached at data address A + 0x20.
- R8: Port 0x3F reads and writes the status byte. An access to it drives no data write, and data address 0x5F is left unchanged.
- R9: Word `1001 010x xxxx 110x` followed by an address word jumps to that word address. The word already fetched behind the jump is discarded. `imem_addr` shows the target two edges after the jump word was fetched.
- R10: A word that matches none of the patterns above, including 0x0000, 0xFFFF and 0x9501, changes no register, no flag and no memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| imem_addr | output | PC_W | Word address of the program word being fetched |
| imem_rdata | input | 16 | Program word at `imem_addr` (combinational read) |
| dmem_addr | output | DA_W | Byte address for a data or port access |
| dmem_we | output | 1 | Data write strobe, taken at the clock edge |
| dmem_wdata | output | 8 | Data byte to write |
| dmem_rdata | input | 8 | Data byte at `dmem_addr` (combinational read) |

## Verification
A wrong program counter or instruction register shows on `imem_addr` at the very next edge. It shows either as a step other than one, or as a jump target reached early, late or not at all. A corrupt register or status bit stays hidden until a store or port write drives it out, so each test ends by writing its results to data memory, including the status byte read through port 0x3F. Most flag errors therefore surface one or two instructions after the arithmetic that caused them. An address word executed by mistake, or a port write to the status byte that leaks onto the bus, shows up in data memory as an extra or altered byte.

// File: rtl/mcu8_pkg.sv
package mcu8_pkg;

  typedef enum logic [3:0] {
    OP_NOP, OP_LDI, OP_ADD, OP_SUB, OP_INC, OP_DEC,
    OP_LDS, OP_STS, OP_IN, OP_OUT, OP_JMP
  } op_e;

  typedef enum logic [1:0] {
    ALU_ADD, ALU_SUB, ALU_INC, ALU_DEC
  } alu_e;

  typedef struct packed {
    op_e        op;
    logic [4:0] rd;
    logic [4:0] rr;
    logic [7:0] imm;
    logic [5:0] io;
    logic       two_word;
  } dec_t;

  localparam int unsigned FLG_C = 0;
  localparam int unsigned FLG_Z = 1;
  localparam int unsigned FLG_N = 2;
  localparam int unsigned FLG_V = 3;
  localparam int unsigned FLG_S = 4;
  localparam int unsigned FLG_H = 5;

endpackage

// File: rtl/mcu8_decode.sv
module mcu8_decode
  import mcu8_pkg::*;
(
  input  logic [15:0] insn,
  output dec_t        dec
);

  always_comb begin
    dec.rd       = insn[8:4];
    dec.rr       = {insn[9], insn[3:0]};
    dec.imm      = {insn[11:8], insn[3:0]};
    dec.io       = {insn[10:9], insn[3:0]};
    dec.two_word = 1'b0;
    dec.op       = OP_NOP;
    if (insn[15:12] == 4'hE) begin
      dec.op = OP_LDI;
      dec.rd = {1'b1, insn[7:4]};
    end else if (insn[15:10] == 6'b000011) begin
      dec.op = OP_ADD;
    end else if (insn[15:10] == 6'b000110) begin
      dec.op = OP_SUB;
    end else if (insn[15:9] == 7'b1001010) begin
      if (insn[3:0] == 4'h3) begin
        dec.op = OP_INC;
      end else if (insn[3:0] == 4'hA) begin
        dec.op = OP_DEC;
      end else if (insn[3:1] == 3'b110) begin
        dec.op       = OP_JMP;
        dec.two_word = 1'b1;
      end
    end else if (insn[15:9] == 7'b1001000 && insn[3:0] == 4'h0) begin
      dec.op       = OP_LDS;
      dec.two_word = 1'b1;
    end else if (insn[15:9] == 7'b1001001 && insn[3:0] == 4'h0) begin
      dec.op       = OP_STS;
      dec.two_word = 1'b1;
    end else if (insn[15:11] == 5'b10110) begin
      dec.op = OP_IN;
    end else if (insn[15:11] == 5'b10111) begin
      dec.op = OP_OUT;
    end
  end

endmodule

// File: rtl/mcu8_flag_alu.sv
module mcu8_flag_alu
  import mcu8_pkg::*;
(
  input  alu_e       op,
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic [7:0] flags_in,
  output logic [7:0] res,
  output logic [7:0] flags_out
);

  logic [8:0] wide;
  logic       half;
  logic       ovf;
  logic       neg;

  always_comb begin
    unique case (op)
      ALU_ADD: wide = {1'b0, a} + {1'b0, b};
      ALU_SUB: wide = {1'b0, a} - {1'b0, b};
      ALU_INC: wide = {1'b0, a} + 9'd1;
      default: wide = {1'b0, a} - 9'd1;
    endcase
    res = wide[7:0];
    neg = wide[7];

    unique case (op)
      ALU_ADD: begin
        half = (a[3] & b[3]) | (b[3] & ~res[3]) | (~res[3] & a[3]);
        ovf  = (a[7] & b[7] & ~res[7]) | (~a[7] & ~b[7] & res[7]);
      end
      ALU_SUB: begin
        half = (~a[3] & b[3]) | (b[3] & res[3]) | (res[3] & ~a[3]);
        ovf  = (a[7] & ~b[7] & ~res[7]) | (~a[7] & b[7] & res[7]);
      end
      ALU_INC: begin
        half = flags_in[FLG_H];
        ovf  = (res == 8'h80);
      end
      default: begin
        half = flags_in[FLG_H];
        ovf  = (a == 8'h80);
      end
    endcase

    flags_out        = flags_in;
    flags_out[FLG_H] = half;
    flags_out[FLG_V] = ovf;
    flags_out[FLG_N] = neg;
    flags_out[FLG_S] = neg ^ ovf;
    flags_out[FLG_Z] = (res == 8'h00);
    if (op == ALU_ADD || op == ALU_SUB) begin
      flags_out[FLG_C] = wide[8];
    end
  end

endmodule

// File: rtl/mcu8_regfile.sv
module mcu8_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned DW   = 8,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);

  logic [DW-1:0] regs [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_entry
    logic          ent_en;
    logic [DW-1:0] ent_q;

    assign ent_en = we && (waddr == AW'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (ent_en) begin
        ent_q <= wdata;
      end
    end

    assign regs[gi] = ent_q;
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/mcu8_core.sv
module mcu8_core
  import mcu8_pkg::*;
#(
  parameter int unsigned PC_W     = 16,
  parameter int unsigned DA_W     = 16,
  parameter logic [7:0]  IO_BASE  = 8'h20,
  parameter logic [5:0]  FLAG_PORT = 6'h3F
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PC_W-1:0] imem_addr,
  input  logic [15:0]     imem_rdata,
  output logic [DA_W-1:0] dmem_addr,
  output logic            dmem_we,
  output logic [7:0]      dmem_wdata,
  input  logic [7:0]      dmem_rdata
);

  localparam int unsigned NREG = 32;

  logic [PC_W-1:0] pc_q, pc_d;
  logic [15:0]     ir_q, ir_d;
  logic [7:0]      sreg_q, sreg_d;
  logic            sreg_en;

  dec_t            dec;
  alu_e            alu_op;
  logic [7:0]      alu_res, alu_flags;
  logic [7:0]      rf_a, rf_b;
  logic            rf_we;
  logic [7:0]      rf_wdata;
  logic            flag_port;
  logic [DA_W-1:0] port_daddr;

  mcu8_decode u_dec (
    .insn (ir_q),
    .dec  (dec)
  );

  mcu8_regfile #(.NREG(NREG), .DW(8)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (dec.rd),
    .wdata   (rf_wdata),
    .raddr_a (dec.rd),
    .raddr_b (dec.rr),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  always_comb begin
    unique case (dec.op)
      OP_SUB:  alu_op = ALU_SUB;
      OP_INC:  alu_op = ALU_INC;
      OP_DEC:  alu_op = ALU_DEC;
      default: alu_op = ALU_ADD;
    endcase
  end

  mcu8_flag_alu u_alu (
    .op        (alu_op),
    .a         (rf_a),
    .b         (rf_b),
    .flags_in  (sreg_q),
    .res       (alu_res),
    .flags_out (alu_flags)
  );

  assign flag_port  = (dec.io == FLAG_PORT);
  assign port_daddr = DA_W'(dec.io) + DA_W'(IO_BASE);
  assign imem_addr  = pc_q;
  assign dmem_wdata = rf_a;

  // next-state: fetch stage
  always_comb begin
    pc_d = pc_q + PC_W'(1);
    ir_d = imem_rdata;
    if (dec.two_word) begin
      ir_d = '0;
    end
    if (dec.op == OP_JMP) begin
      pc_d = PC_W'(imem_rdata);
    end
  end

  // next-state: execute stage
  always_comb begin
    rf_we     = 1'b0;
    rf_wdata  = 8'h00;
    sreg_d    = sreg_q;
    sreg_en   = 1'b0;
    dmem_addr = port_daddr;
    dmem_we   = 1'b0;
    unique case (dec.op)
      OP_LDI: begin
        rf_we    = 1'b1;
        rf_wdata = dec.imm;
      end
      OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
        rf_we    = 1'b1;
        rf_wdata = alu_res;
        sreg_d   = alu_flags;
        sreg_en  = 1'b1;
      end
      OP_LDS: begin
        dmem_addr = DA_W'(imem_rdata);
        rf_we     = 1'b1;
        rf_wdata  = dmem_rdata;
      end
      OP_STS: begin
        dmem_addr = DA_W'(imem_rdata);
        dmem_we   = 1'b1;
      end
      OP_IN: begin
        rf_we    = 1'b1;
        rf_wdata = flag_port ? sreg_q : dmem_rdata;
      end
      OP_OUT: begin
        if (flag_port) begin
          sreg_d  = rf_a;
          sreg_en = 1'b1;
        end else begin
          dmem_we = 1'b1;
        end
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      pc_q <= pc_d;
      ir_q <= ir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
    end else if (sreg_en) begin
      sreg_q <= sreg_d;
    end
  end

endmodule

// File: rtl/mcu8_core_chk.sv
module mcu8_core_chk #(
  parameter int unsigned PC_W = 16,
  parameter int unsigned DA_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] imem_addr,
  input logic [15:0]     imem_rdata,
  input logic [DA_W-1:0] dmem_addr,
  input logic            dmem_we,
  input logic [15:0]     ir_q
);

  logic       c_jmp, c_lds, c_sts, c_out;
  logic [5:0] c_port;

  assign c_jmp  = (ir_q[15:9] == 7'b1001010) && (ir_q[3:1] == 3'b110);
  assign c_lds  = (ir_q[15:9] == 7'b1001000) && (ir_q[3:0] == 4'h0);
  assign c_sts  = (ir_q[15:9] == 7'b1001001) && (ir_q[3:0] == 4'h0);
  assign c_out  = (ir_q[15:11] == 5'b10111);
  assign c_port = {ir_q[10:9], ir_q[3:0]};

  // R2
  seq_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !c_jmp |=> imem_addr == $past(imem_addr) + PC_W'(1));

  // R9
  jmp_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_jmp |=> imem_addr == $past(imem_rdata[PC_W-1:0]));

  // R6
  addr_word_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_jmp || c_lds || c_sts) |=> ir_q == 16'h0000);

  // R6
  sts_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_sts |-> dmem_we && dmem_addr == DA_W'(imem_rdata));

  // R7
  out_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_out && c_port != 6'h3F) |-> dmem_we && dmem_addr == DA_W'(c_port) + DA_W'(8'h20));

  // R8
  flag_port_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_out && c_port == 6'h3F) |-> !dmem_we);

  // R6
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (c_sts || c_out));

endmodule

bind mcu8_core mcu8_core_chk #(.PC_W(PC_W), .DA_W(DA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .imem_addr  (imem_addr),
  .imem_rdata (imem_rdata),
  .dmem_addr  (dmem_addr),
  .dmem_we    (dmem_we),
  .ir_q       (ir_q)
);

// File: tb/sim_mcu8_core.sv
module sim_mcu8_core;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [15:0] imem_addr;
  logic [15:0] imem_rdata;
  logic [15:0] dmem_addr;
  logic        dmem_we;
  logic [7:0]  dmem_wdata;
  logic [7:0]  dmem_rdata;

  logic [15:0] prog [0:255];
  logic [7:0]  dmem [0:4095];
  int          total;
  int          bad;
  int          pp;

  mcu8_core u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_we    (dmem_we),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  assign imem_rdata = prog[imem_addr[7:0]];
  assign dmem_rdata = dmem[dmem_addr[11:0]];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr[11:0]] <= dmem_wdata;
  end

  function automatic logic [15:0] w_ldi(logic [4:0] d, logic [7:0] k);
    return {4'hE, k[7:4], d[3:0], k[3:0]};
  endfunction
  function automatic logic [15:0] w_add(logic [4:0] d, logic [4:0] r);
    return {6'b000011, r[4], d, r[3:0]};
  endfunction
  function automatic logic [15:0] w_sub(logic [4:0] d, logic [4:0] r);
    return {6'b000110, r[4], d, r[3:0]};
  endfunction
  function automatic logic [15:0] w_inc(logic [4:0] d);
    return {7'b1001010, d, 4'h3};
  endfunction
  function automatic logic [15:0] w_dec(logic [4:0] d);
    return {7'b1001010, d, 4'hA};
  endfunction
  function automatic logic [15:0] w_lds(logic [4:0] d);
    return {7'b1001000, d, 4'h0};
  endfunction
  function automatic logic [15:0] w_sts(logic [4:0] r);
    return {7'b1001001, r, 4'h0};
  endfunction
  function automatic logic [15:0] w_in(logic [4:0] d, logic [5:0] a);
    return {5'b10110, a[5:4], d, a[3:0]};
  endfunction
  function automatic logic [15:0] w_out(logic [5:0] a, logic [4:0] r);
    return {5'b10111, a[5:4], r, a[3:0]};
  endfunction

  task automatic emit(logic [15:0] w);
    prog[pp[7:0]] = w;
    pp++;
  endtask

  task automatic emit_sts(logic [4:0] r, logic [15:0] a);
    emit(w_sts(r));
    emit(a);
  endtask

  task automatic emit_flags(logic [4:0] tmp, logic [15:0] a);
    emit(w_in(tmp, 6'h3F));
    emit_sts(tmp, a);
  endtask

  task automatic emit_halt();
    int here;
    here = pp;
    emit(16'h940C);
    emit(16'(here));
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) prog[i] = 16'h0000;
    for (int i = 0; i < 4096; i++) dmem[i] = 8'h00;
    pp = 0;
  endtask

  task automatic run(int ncyc);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (ncyc) @(negedge clk);
  endtask

  task automatic t_reset();
    clear_all();
    dmem[16'h10] = 8'hEE;
    dmem[16'h11] = 8'hEE;
    emit_sts(5'd5, 16'h0010);
    emit_flags(5'd6, 16'h0011);
    emit_halt();
    @(negedge clk);
    chk("R1 imem_addr in reset", imem_addr, 16'h0000);
    chk("R1 dmem_we in reset", {15'b0, dmem_we}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 first step", imem_addr, 16'h0001);
    @(negedge clk);
    chk("R2 second step", imem_addr, 16'h0002);
    repeat (30) @(negedge clk);
    chk("R1 register cleared", {8'h00, dmem[16'h10]}, 16'h0000);
    chk("R1 status cleared", {8'h00, dmem[16'h11]}, 16'h0000);
  endtask

  task automatic t_ldi_sts();
    clear_all();
    emit(16'hE205);
    emit(16'h9300);
    emit(16'h0300);
    emit(w_ldi(5'd31, 8'hA7));
    emit_sts(5'd31, 16'h0301);
    emit_flags(5'd20, 16'h0302);
    emit_halt();
    run(40);
    chk("R3 ldi r16", {8'h00, dmem[16'h300]}, 16'h0025);
    chk("R3 ldi r31", {8'h00, dmem[16'h301]}, 16'h00A7);
    chk("R3 flags untouched", {8'h00, dmem[16'h302]}, 16'h0000);
  endtask

  task automatic t_add();
    clear_all();
    emit(w_ldi(5'd16, 8'd19));
    emit(w_ldi(5'd20, 8'd95));
    emit(w_add(5'd16, 5'd20));
    emit_sts(5'd16, 16'h0090);
    emit(w_ldi(5'd16, 8'h38));
    emit(w_ldi(5'd17, 8'h2F));
    emit(w_add(5'd16, 5'd17));
    emit_sts(5'd16, 16'h0091);
    emit_flags(5'd25, 16'h0092);
    emit(w_ldi(5'd20, 8'h9C));
    emit(w_ldi(5'd21, 8'h64));
    emit(w_add(5'd20, 5'd21));
    emit_sts(5'd20, 16'h0093);
    emit_flags(5'd25, 16'h0094);
    emit(w_add(5'd0, 5'd21));
    emit_sts(5'd0, 16'h0095);
    emit_halt();
    run(60);
    chk("R4 19+95", {8'h00, dmem[16'h90]}, 16'h0072);
    chk("R4 38+2F", {8'h00, dmem[16'h91]}, 16'h0067);
    chk("R4 flags H only", {8'h00, dmem[16'h92]}, 16'h0020);
    chk("R4 9C+64", {8'h00, dmem[16'h93]}, 16'h0000);
    chk("R4 flags H Z C", {8'h00, dmem[16'h94]}, 16'h0023);
    chk("R4 low reg dest", {8'h00, dmem[16'h95]}, 16'h0064);
  endtask

  task automatic t_sub();
    clear_all();
    emit(w_ldi(5'd20, 8'hA5));
    emit(w_ldi(5'd21, 8'h23));
    emit(w_sub(5'd20, 5'd21));
    emit_sts(5'd20, 16'h00A0);
    emit_flags(5'd25, 16'h00A1);
    emit(w_ldi(5'd20, 8'h52));
    emit(w_ldi(5'd21, 8'h73));
    emit(w_sub(5'd20, 5'd21));
    emit_sts(5'd20, 16'h00A2);
    emit_flags(5'd25, 16'h00A3);
    emit(w_ldi(5'd20, 8'h9C));
    emit(w_ldi(5'd21, 8'h9C));
    emit(w_sub(5'd20, 5'd21));
    emit_sts(5'd20, 16'h00A4);
    emit_flags(5'd25, 16'h00A5);
    emit_halt();
    run(60);
    chk("R4 A5-23", {8'h00, dmem[16'hA0]}, 16'h0082);
    chk("R4 flags S N", {8'h00, dmem[16'hA1]}, 16'h0014);
    chk("R4 52-73", {8'h00, dmem[16'hA2]}, 16'h00DF);
    chk("R4 flags borrow", {8'h00, dmem[16'hA3]}, 16'h0035);
    chk("R4 9C-9C", {8'h00, dmem[16'hA4]}, 16'h0000);
    chk("R4 flags Z only", {8'h00, dmem[16'hA5]}, 16'h0002);
  endtask

  task automatic t_incdec();
    clear_all();
    emit(w_ldi(5'd18, 8'hFF));
    emit(w_ldi(5'd19, 8'h01));
    emit(w_add(5'd18, 5'd19));
    emit(w_ldi(5'd20, 8'h7F));
    emit(w_inc(5'd20));
    emit_sts(5'd20, 16'h00B0);
    emit_flags(5'd25, 16'h00B1);
    emit(w_ldi(5'd21, 8'h9C));
    emit(w_sub(5'd21, 5'd21));
    emit(w_ldi(5'd22, 8'h80));
    emit(w_dec(5'd22));
    emit_sts(5'd22, 16'h00B2);
    emit_flags(5'd25, 16'h00B3);
    emit(w_ldi(5'd23, 8'h01));
    emit(w_dec(5'd23));
    emit_sts(5'd23, 16'h00B4);
    emit_flags(5'd25, 16'h00B5);
    emit_halt();
    run(60);
    chk("R5 inc 7F", {8'h00, dmem[16'hB0]}, 16'h0080);
    chk("R5 inc keeps H C", {8'h00, dmem[16'hB1]}, 16'h002D);
    chk("R5 dec 80", {8'h00, dmem[16'hB2]}, 16'h007F);
    chk("R5 dec overflow", {8'h00, dmem[16'hB3]}, 16'h0018);
    chk("R5 dec to zero", {8'h00, dmem[16'hB4]}, 16'h0000);
    chk("R5 dec zero flags", {8'h00, dmem[16'hB5]}, 16'h0002);
  endtask

  task automatic t_io();
    clear_all();
    dmem[16'h36] = 8'h11;
    dmem[16'h5F] = 8'hAA;
    emit(w_ldi(5'd20, 8'h53));
    emit(w_out(6'h3E, 5'd20));
    emit(w_in(5'd21, 6'h16));
    emit(w_inc(5'd21));
    emit_sts(5'd21, 16'h0091);
    emit(w_ldi(5'd22, 8'hC3));
    emit(w_out(6'h3F, 5'd22));
    emit(w_in(5'd23, 6'h3F));
    emit_sts(5'd23, 16'h0092);
    emit_halt();
    run(40);
    chk("R7 out to 0x5E", {8'h00, dmem[16'h5E]}, 16'h0053);
    chk("R7 in from 0x36", {8'h00, dmem[16'h91]}, 16'h0012);
    chk("R8 status via port", {8'h00, dmem[16'h92]}, 16'h00C3);
    chk("R8 0x5F untouched", {8'h00, dmem[16'h5F]}, 16'h00AA);
  endtask

  task automatic t_lds();
    clear_all();
    dmem[16'h200] = 8'h40;
    dmem[16'h220] = 8'h05;
    emit(w_lds(5'd20));
    emit(16'h0200);
    emit(w_lds(5'd21));
    emit(16'h0220);
    emit(w_add(5'd20, 5'd21));
    emit_sts(5'd20, 16'h0230);
    emit(w_ldi(5'd16, 8'h05));
    emit(w_ldi(5'd17, 8'h03));
    emit_sts(5'd16, 16'h0F01);
    emit_sts(5'd16, 16'h0F02);
    emit_halt();
    run(40);
    chk("R6 load add store", {8'h00, dmem[16'h230]}, 16'h0045);
    chk("R6 first store", {8'h00, dmem[16'hF01]}, 16'h0005);
    chk("R6 address word not run", {8'h00, dmem[16'hF02]}, 16'h0005);
  endtask

  task automatic t_jump();
    clear_all();
    emit(w_ldi(5'd16, 8'h25));
    emit(w_ldi(5'd17, 8'h34));
    emit(w_ldi(5'd18, 8'h31));
    emit(w_add(5'd16, 5'd17));
    emit(w_add(5'd16, 5'd18));
    emit(w_ldi(5'd17, 8'd11));
    emit(w_add(5'd16, 5'd17));
    emit_sts(5'd16, 16'h0300);
    emit_halt();
    run(40);
    chk("R9 program then self loop", {8'h00, dmem[16'h300]}, 16'h0095);

    clear_all();
    emit(w_ldi(5'd16, 8'h11));
    emit(16'h940C);
    emit(16'h0005);
    emit(w_ldi(5'd16, 8'h77));
    emit(w_ldi(5'd16, 8'h66));
    emit_sts(5'd16, 16'h0100);
    emit_halt();
    run(30);
    chk("R9 skipped words", {8'h00, dmem[16'h100]}, 16'h0011);

    clear_all();
    prog[0] = 16'h940C;
    prog[1] = 16'h0004;
    prog[4] = 16'h940C;
    prog[5] = 16'h0004;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 fetch of address word", imem_addr, 16'h0001);
    @(negedge clk);
    chk("R9 target on bus", imem_addr, 16'h0004);
    @(negedge clk);
    chk("R9 resumes after target", imem_addr, 16'h0005);
  endtask

  task automatic t_nop();
    clear_all();
    emit(w_ldi(5'd16, 8'h09));
    emit(16'hFFFF);
    emit(16'h0000);
    emit(16'h9501);
    emit_sts(5'd16, 16'h0093);
    emit_flags(5'd25, 16'h0094);
    emit_halt();
    run(30);
    chk("R10 register kept", {8'h00, dmem[16'h93]}, 16'h0009);
    chk("R10 flags kept", {8'h00, dmem[16'h94]}, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad   = 0;
    rst_n = 1'b1;
    #1;
    rst_n = 1'b0;
    t_reset();
    t_ldi_sts();
    t_add();
    t_sub();
    t_incdec();
    t_io();
    t_lds();
    t_jump();
    t_nop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule